// File: doc/BRIEF.md
# Six-Channel Compare Timer Bank

This block holds six up-counting timers. A small register bus reaches all of them. Each timer has a settings word, a live count and a compare value. A shared tick-enable input advances every enabled timer by one. When a timer ticks while its count equals its compare value, a match event occurs. The settings word then decides what the timer does next: return to zero, freeze, or roll over naturally at its full width. A timer can also drive a pulse-width output whose active level can be inverted.

Match events are gathered in one status word. That word holds one match flag and one interrupt flag per timer. Software clears a flag by writing a one to it. A single interrupt line is high while any interrupt flag is set. The block contains no clock divider. Whatever logic produces `tick_en` decides the counting rate.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every settings word, count, compare value and status flag is zero, and `irq_out`, `pwm_out` and `bus_rdata` are low.
- R2: Timer i uses byte addresses 0x10*i + 0 (settings), + 4 (count) and + 8 (compare). The status word is at 0x60. `bus_rdata` shows the addressed value on the cycle after `bus_rd` is sampled. An unmapped address reads as zero.
- R3: A timer whose settings bit 0 is set increments by one on each cycle with `tick_en` high. With bit 0 clear or `tick_en` low, its count holds.
- R4: Timers 0 to 3 are 16 bits wide and timers 4 and 5 are 20 bits wide. A write to a count keeps only that timer's width. If neither settings bit 1 nor bit 9 is set, the count rolls over from all-ones to zero.
- R5: A match event is a counting cycle in which count equals compare. It sets status bit 8+i. It sets status bit i only when settings bit 3 is set.
- R6: With settings bit 1 set, a match event loads zero into the count. Bit 1 takes precedence over bit 9.
- R7: With settings bit 9 set and bit 1 clear, a match event freezes the count at the compare value. No further match events occur until one of three writes: a settings write with bit 0 set, a settings write with bit 8 set, or a count write.
- R8: Writing settings bit 8 forces the count to zero on the next cycle. Bit 8 always reads back as zero.
- R9: Settings bits 4 to 7 are stored and read back. Bits 4 to 6 have no effect on counting.
- R10: `pwm_out[i]` is registered. With settings bit 2 set, it equals bit 7 XOR (count < compare). With bit 2 clear, it equals bit 7.
- R11: Writing ones to the status word clears the matching flags. A match event in the same cycle wins over the clear.
- R12: `irq_out` is the OR of status bits 0 to 5 and changes on the same cycle as those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-advance qualifier shared by all timers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 6 | Per-timer pulse-width outputs |
| irq_out | output | 1 | OR of the interrupt flags |

## Verification
Two cases are hard to reach from the ports. The first is a status clear that lands in the same cycle as a new match. The bench presets a count to equal its compare value. It then raises `tick_en` and the status write on the same clock edge, so the set-wins rule is tested directly. The second is the freeze mode. The bench keeps ticking a frozen timer after its flags are cleared and confirms that no new flag appears. It then re-enables the timer and watches the match come back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CFG_W       = 10;
  localparam int B_EN        = 0;
  localparam int B_CONT      = 1;
  localparam int B_PWM       = 2;
  localparam int B_IEN       = 3;
  localparam int B_POL       = 7;
  localparam int B_ZERO      = 8;
  localparam int B_HALT      = 9;
  localparam int OFF_CFG     = 0;
  localparam int OFF_CNT     = 4;
  localparam int OFF_REF     = 8;
  localparam int STATUS_ADDR = 8'h60;
  localparam int REF_FLAG_LSB = 8;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic             cnt_we,
  input  logic             ref_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [CW-1:0]    val_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CW-1:0]    cnt_q,
  output logic [CW-1:0]    ref_q,
  output logic             hit,
  output logic             pwm_q
);
  logic halt_q;
  logic run;

  assign run = cfg_q[B_EN] && !halt_q && tick;
  assign hit = run && (cnt_q == ref_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      ref_q  <= '0;
      halt_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q         <= cfg_wdata;
        cfg_q[B_ZERO] <= 1'b0;
      end
      if (ref_we) ref_q <= val_wdata;

      if (cfg_we && cfg_wdata[B_ZERO]) begin
        cnt_q  <= '0;
        halt_q <= 1'b0;
      end else if (cnt_we) begin
        cnt_q  <= val_wdata;
        halt_q <= 1'b0;
      end else if (run) begin
        if (hit && cfg_q[B_CONT])      cnt_q  <= '0;
        else if (hit && cfg_q[B_HALT]) halt_q <= 1'b1;
        else                           cnt_q  <= cnt_q + 1'b1;
      end
      if (cfg_we && cfg_wdata[B_EN]) halt_q <= 1'b0;

      pwm_q <= cfg_q[B_POL] ^ (cfg_q[B_PWM] && (cnt_q < ref_q));
    end
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] ien,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_irq,
  input  logic [NUM_CH-1:0] clr_ref,
  output logic [NUM_CH-1:0] irq_flags,
  output logic [NUM_CH-1:0] ref_flags,
  output logic              irq_out
);
  logic [NUM_CH-1:0] irq_next, ref_next;

  always_comb begin
    irq_next = irq_flags;
    ref_next = ref_flags;
    if (clr_we) begin
      irq_next = irq_next & ~clr_irq;
      ref_next = ref_next & ~clr_ref;
    end
    irq_next = irq_next | (hit & ien);
    ref_next = ref_next | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flags <= '0;
      ref_flags <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_flags <= irq_next;
      ref_flags <= ref_next;
      irq_out   <= |irq_next;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH     = 6,
  parameter int NUM_NARROW = 4,
  parameter int NARROW_W   = 16,
  parameter int WIDE_W     = 20,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              irq_out
);
  localparam int SEL_W = ADDR_W - 4;

  logic [SEL_W-1:0] ch_sel;
  logic [3:0]       reg_off;
  logic             status_hit;

  logic [NUM_CH-1:0][CFG_W-1:0]  cfg_all;
  logic [NUM_CH-1:0][WIDE_W-1:0] cnt_all;
  logic [NUM_CH-1:0][WIDE_W-1:0] ref_all;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0]             ien;
  logic [NUM_CH-1:0]             irq_flags, ref_flags;
  logic [DATA_W-1:0]             rd_val;

  assign ch_sel     = bus_addr[ADDR_W-1:4];
  assign reg_off    = bus_addr[3:0];
  assign status_hit = (bus_addr == ADDR_W'(STATUS_ADDR));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int CW = (i < NUM_NARROW) ? NARROW_W : WIDE_W;
    logic          sel;
    logic [CW-1:0] cnt_w, ref_w;

    assign sel = bus_wr && (ch_sel == SEL_W'(i));

    tmr_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick_en),
      .cfg_we    (sel && reg_off == 4'(OFF_CFG)),
      .cnt_we    (sel && reg_off == 4'(OFF_CNT)),
      .ref_we    (sel && reg_off == 4'(OFF_REF)),
      .cfg_wdata (bus_wdata[CFG_W-1:0]),
      .val_wdata (bus_wdata[CW-1:0]),
      .cfg_q     (cfg_all[i]),
      .cnt_q     (cnt_w),
      .ref_q     (ref_w),
      .hit       (hit[i]),
      .pwm_q     (pwm_out[i])
    );

    assign cnt_all[i] = WIDE_W'(cnt_w);
    assign ref_all[i] = WIDE_W'(ref_w);
    assign ien[i]     = cfg_all[i][B_IEN];
  end

  tmr_status #(.NUM_CH(NUM_CH)) u_status (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .ien       (ien),
    .clr_we    (bus_wr && status_hit),
    .clr_irq   (bus_wdata[NUM_CH-1:0]),
    .clr_ref   (bus_wdata[REF_FLAG_LSB +: NUM_CH]),
    .irq_flags (irq_flags),
    .ref_flags (ref_flags),
    .irq_out   (irq_out)
  );

  always_comb begin
    rd_val = '0;
    if (status_hit) begin
      rd_val[NUM_CH-1:0]             = irq_flags;
      rd_val[REF_FLAG_LSB +: NUM_CH] = ref_flags;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_sel == SEL_W'(i)) begin
          case (reg_off)
            4'(OFF_CFG): rd_val = DATA_W'(cfg_all[i]);
            4'(OFF_CNT): rd_val = DATA_W'(cnt_all[i]);
            4'(OFF_REF): rd_val = DATA_W'(ref_all[i]);
            default:     rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WIDE_W = 20,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [DATA_W-1:0]               bus_wdata,
  input logic [NUM_CH-1:0][CFG_W-1:0]    cfg_all,
  input logic [NUM_CH-1:0][WIDE_W-1:0]   cnt_all,
  input logic [NUM_CH-1:0]               hit,
  input logic [NUM_CH-1:0]               irq_flags,
  input logic [NUM_CH-1:0]               pwm_out,
  input logic                            irq_out
);
  // R8: a zeroing settings write to timer 0 leaves its count at zero
  a_r8_zero_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && bus_wdata[B_ZERO]) |=> (cnt_all[0] == '0));

  // R3: a disabled timer 0 with no bus write holds its count
  a_r3_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!cfg_all[0][B_EN] && !bus_wr) |=> $stable(cnt_all[0]));

  // R12: the interrupt line tracks the flags and only rises after a match
  a_r12_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|irq_flags));
  a_r12_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|hit));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5: an interrupt flag rises only after a match with interrupts enabled
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_flags[i]) |-> $past(hit[i] && cfg_all[i][B_IEN]));
    // R10: outside pulse-width mode the output sits at the polarity level
    a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
      !cfg_all[i][B_PWM] |=> (pwm_out[i] == $past(cfg_all[i][B_POL])));
  end
endmodule

bind tmr_bank tmr_bank_chk #(
  .NUM_CH(NUM_CH), .WIDE_W(WIDE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cfg_all(cfg_all), .cnt_all(cnt_all), .hit(hit),
  .irq_flags(irq_flags), .pwm_out(pwm_out), .irq_out(irq_out)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [5:0]  pwm_out;
  logic        irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ad(input int ch, input int off);
    return 8'(ch * 16 + off);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h60, v);        check("R1 status", v, 0);
    rd(ad(0, 0), v);     check("R1 cfg0", v, 0);
    rd(ad(4, 4), v);     check("R1 cnt4", v, 0);
    rd(ad(5, 8), v);     check("R1 ref5", v, 0);
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 pwm_out", 32'(pwm_out), 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(ad(3, 8), 32'h1234);
    wr(ad(5, 8), 32'hABCDE);
    rd(ad(3, 8), v);  check("R2 ref3", v, 32'h1234);
    rd(ad(5, 8), v);  check("R2 ref5", v, 32'hABCDE);
    rd(8'h70, v);     check("R2 unmapped 0x70", v, 0);
    rd(ad(3, 12), v); check("R2 unmapped 0x3C", v, 0);
    wr(ad(3, 8), 0);
    wr(ad(5, 8), 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(ad(0, 8), 32'hFFFF);
    wr(ad(0, 0), 32'h1);
    ticks(5);
    rd(ad(0, 4), v); check("R3 count after 5 ticks", v, 5);
    idle(3);
    rd(ad(0, 4), v); check("R3 hold without tick", v, 5);
    rd(ad(1, 4), v); check("R3 disabled timer", v, 0);
    wr(ad(0, 0), 0);
  endtask

  task automatic t_width();
    logic [31:0] v;
    wr(ad(2, 4), 32'h3FFFF);
    rd(ad(2, 4), v); check("R4 narrow truncate", v, 32'hFFFF);
    wr(ad(4, 4), 32'h3FFFFF);
    rd(ad(4, 4), v); check("R4 wide truncate", v, 32'hFFFFF);
    wr(ad(2, 8), 32'h10);
    wr(ad(2, 0), 32'h1);
    wr(ad(4, 0), 32'h1);
    ticks(1);
    wr(ad(2, 0), 0);
    wr(ad(4, 0), 0);
    rd(ad(2, 4), v); check("R4 narrow rollover", v, 0);
    rd(ad(4, 4), v); check("R4 wide rollover", v, 0);
    rd(8'h60, v);    check("R4 no match on rollover", v, 0);
  endtask

  task automatic t_cont();
    logic [31:0] v;
    wr(ad(1, 8), 3);
    wr(ad(1, 0), 32'hB);
    ticks(4);
    rd(ad(1, 4), v); check("R6 continue reload", v, 0);
    rd(8'h60, v);    check("R5 flags with irq enable", v, 32'h0202);
    check("R12 irq_out high", 32'(irq_out), 1);
    wr(ad(1, 0), 0);
    wr(8'h60, 32'h0202);
    rd(8'h60, v);    check("R11 clear", v, 0);
    check("R12 irq_out low", 32'(irq_out), 0);
    wr(ad(3, 8), 2);
    wr(ad(3, 0), 32'h203);
    ticks(3);
    wr(ad(3, 0), 0);
    rd(ad(3, 4), v); check("R6 continue beats stop", v, 0);
    rd(8'h60, v);    check("R5 no irq flag when disabled", v, 32'h0800);
    check("R12 irq_out stays low", 32'(irq_out), 0);
    wr(8'h60, 32'h3F3F);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(ad(5, 8), 2);
    wr(ad(5, 0), 32'h201);
    ticks(5);
    rd(ad(5, 4), v); check("R7 frozen at compare", v, 2);
    rd(8'h60, v);    check("R7 match flag", v, 32'h2000);
    wr(8'h60, 32'h2000);
    ticks(3);
    rd(8'h60, v);    check("R7 no new match while frozen", v, 0);
    rd(ad(5, 4), v); check("R7 still frozen", v, 2);
    wr(ad(5, 0), 32'h201);
    ticks(1);
    rd(8'h60, v);    check("R7 resumes after re-enable", v, 32'h2000);
    wr(ad(5, 0), 0);
    wr(8'h60, 32'h3F3F);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(ad(0, 4), 32'h77);
    wr(ad(0, 0), 32'h170);
    rd(ad(0, 4), v); check("R8 zeroed count", v, 0);
    rd(ad(0, 0), v); check("R9 settings readback, R8 bit clear", v, 32'h070);
    wr(ad(0, 0), 32'h71);
    ticks(3);
    rd(ad(0, 4), v); check("R9 source bits do not slow counting", v, 3);
    wr(ad(0, 0), 0);
  endtask

  task automatic t_pwm();
    logic [31:0] v;
    wr(ad(2, 4), 0);
    wr(ad(2, 8), 4);
    wr(ad(2, 0), 32'h5);
    ticks(2);
    idle(1);
    check("R10 active below compare", 32'(pwm_out), 32'h04);
    ticks(3);
    idle(1);
    check("R10 inactive past compare", 32'(pwm_out), 0);
    wr(ad(2, 0), 32'h85);
    idle(1);
    check("R10 inverted polarity", 32'(pwm_out), 32'h04);
    wr(ad(2, 0), 32'h80);
    idle(1);
    check("R10 idle level follows polarity", 32'(pwm_out), 32'h04);
    wr(ad(2, 0), 0);
    idle(1);
    check("R10 idle level low", 32'(pwm_out), 0);
    wr(8'h60, 32'h3F3F);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(ad(4, 8), 1);
    wr(ad(4, 4), 1);
    wr(ad(4, 0), 32'h9);
    tick_en = 1'b1;
    wr(8'h60, 32'h1010);
    tick_en = 1'b0;
    wr(ad(4, 0), 0);
    rd(8'h60, v);    check("R11 set wins over clear", v, 32'h1010);
    check("R12 irq_out on timer 4", 32'(irq_out), 1);
    wr(8'h60, 32'h1010);
    rd(8'h60, v);    check("R11 later clear", v, 0);
  endtask

  initial begin
    rst = 1'b1; tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_map();
    t_count();
    t_width();
    t_cont();
    t_stop();
    t_zero();
    t_pwm();
    t_set_wins();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
      end
    end
  end
endmodule